// File: doc/BRIEF.md
# Indirect Host Register Port with Command Queue

This block sits between a host processor bus and the command engine of a graphics controller. The host sees only two 16-bit word locations, chosen by a register-select input. The first location is used to steer: writing it latches a register pointer, and reading it returns a status word with that pointer alongside. The second location opens onto a small bank of internal registers, and the latched pointer picks which one.

One register in the bank is a FIFO port. Host writes to it queue command words in an eight-word write FIFO. Host reads from it drain an eight-word read FIFO, which the engine side fills. When the command register is free, it takes the oldest queued word by itself. A control register can pause that fetch, abort everything, and choose which status conditions raise the interrupt output. The command executor is stood in for by a `exec_done` pulse, and a hook input fills the read FIFO.

Top module: `hostreg_port`

## Requirements
- R1: A write with `rs`=0 loads the low AW bits of `wdata` into the register pointer. A read with `rs`=0 returns the pointer in bits [15:8] and the status in bits [6:0]. Bit 7 reads 0.
- R2: The status bits are: bit0 write FIFO empty, bit1 write FIFO full (8 words), bit2 read FIFO holds data, bit3 command busy, bit4 write overflow, bit5 read underflow, bit6 interrupt pending.
- R3: With `rs`=1, the pointer picks the target register. Pointer 0 is the FIFO port, 1 is the control register, and 2 is the command register, which is read-only. Pointer 3 reads 0. Writes to pointer 2 and pointer 3 change nothing.
- R4: Host writes to pointer 0 enter the write FIFO in order. A write while 8 words are queued is dropped and sets the sticky overflow bit.
- R5: Host reads of pointer 0 return read FIFO words, oldest first. A read while that FIFO is empty returns 0 and sets the sticky underflow bit. The hook input fills the read FIFO, and hook pushes beyond 8 words are dropped.
- R6: Reading the status word clears the overflow and underflow bits. That same read still returns their old values.
- R7: When the command register is not busy, not paused, and the write FIFO is not empty, the next clock moves the oldest word into `cmd_word` and sets busy. A pulse on `exec_done` while busy clears busy.
- R8: Control bit 1 (pause) stops new fetches. A command already running still completes on `exec_done`.
- R9: Writing control bit 0 as 1 aborts: both FIFOs empty, busy clears and `cmd_word` becomes 0. Bit 0 always reads back as 0.
- R10: Control bits [7:2] enable status bits [5:0]. `irq` is high whenever any enabled status bit is set.
- R11: After reset the pointer, the control register, `cmd_word` and busy are all 0, both FIFOs are empty, `irq` is low, and the status read is 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rs | input | 1 | Register select: 0 pointer/status, 1 indirect bank |
| wr_en | input | 1 | One-cycle host write strobe |
| rd_en | input | 1 | One-cycle host read strobe |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, valid while `rd_en` is high |
| exec_done | input | 1 | Executor finished the current command |
| hook_push | input | 1 | Push `hook_data` into the read FIFO |
| hook_data | input | 16 | Data word for the read FIFO |
| cmd_word | output | 16 | Current command register |
| cmd_busy | output | 1 | A command is executing |
| irq | output | 1 | Interrupt request |

## Verification
The write-FIFO path is swept at every fill level from 0 to 10 words. The same sweep checks both the status flags at each level and the order in which the fetch path hands the words out, so a lost word, a reordered word and an off-by-one full flag each show up as a different failure. The read FIFO is swept the same way from the hook side, through to one read past empty, so the values delivered and the sticky underflow bit with its clear-on-read are checked together. Each interrupt enable is tried alone against two known status vectors. This tells a wrong enable-to-status mapping apart from a missing enable. Pause is applied with a command still running, and abort with words queued in both FIFOs.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  // status bit positions
  localparam int ST_WF_EMPTY = 0;
  localparam int ST_WF_FULL  = 1;
  localparam int ST_RF_READY = 2;
  localparam int ST_BUSY     = 3;
  localparam int ST_OVF      = 4;
  localparam int ST_UNF      = 5;
  localparam int ST_IRQ      = 6;
  localparam int ST_W        = 7;
  // indirect bank addresses
  localparam int RA_FIFO = 0;
  localparam int RA_CTRL = 1;
  localparam int RA_CMD  = 2;
  // control bits
  localparam int CB_ABORT  = 0;
  localparam int CB_PAUSE  = 1;
  localparam int CB_IE_LSB = 2;

  function automatic int unsigned occ_next(int unsigned occ, logic inc, logic dec);
    int unsigned n;
    n = occ;
    if (inc && !dec) n = occ + 1;
    if (dec && !inc) n = occ - 1;
    return n;
  endfunction

  function automatic logic irq_of(logic [5:0] st, logic [5:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/hostreg_fifo.sv
module hostreg_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic          push_drop,
  output logic          pop_miss
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic          push_ok, pop_ok;

  assign empty     = (occ == '0);
  assign full      = (occ == CW'(DEPTH));
  assign push_ok   = push && !full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign push_drop = push && full && !flush;
  assign pop_miss  = pop && empty && !flush;
  assign dout      = mem[rd_ptr];

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      occ <= CW'(hostreg_pkg::occ_next(32'(occ), push_ok, pop_ok));
    end
  end

  assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);
  assert_empty_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> empty);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/hostreg_cmd_fetch.sv
module hostreg_cmd_fetch #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          pause,
  input  logic          done,
  input  logic          q_empty,
  input  logic [DW-1:0] q_head,
  output logic          fetch,
  output logic [DW-1:0] cmd_word,
  output logic          busy
);
  assign fetch = !busy && !pause && !q_empty && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      busy     <= 1'b0;
      cmd_word <= '0;
    end else if (fetch) begin
      busy     <= 1'b1;
      cmd_word <= q_head;
    end else if (busy && done) begin
      busy <= 1'b0;
    end
  end

  assert_no_fetch_paused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(pause));
  assert_done_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done && !abort) |=> !busy);
  assert_abort_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && cmd_word == '0));
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port #(
  parameter int DW         = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int AW         = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rs,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          exec_done,
  input  logic          hook_push,
  input  logic [DW-1:0] hook_data,
  output logic [DW-1:0] cmd_word,
  output logic          cmd_busy,
  output logic          irq
);
  import hostreg_pkg::*;

  logic [AW-1:0]   addr_q;
  logic [7:1]      ctrl_q;
  logic            ovf_q, unf_q;
  logic            ptr_wr, stat_rd, bank_wr, bank_rd;
  logic            sel_fifo, sel_ctrl, sel_cmd;
  logic            wf_push, rf_pop, abort_req;
  logic            wf_empty, wf_full, wf_drop, wf_pop_unused, wf_miss_unused;
  logic            rf_empty, rf_full_unused, rf_drop_unused, rf_miss;
  logic [DW-1:0]   wf_head, rf_head;
  logic            fetch;
  logic [ST_W-1:0] stat;
  logic            wdata_unused;

  assign wdata_unused = ^wdata;

  assign ptr_wr  = wr_en && !rs;
  assign stat_rd = rd_en && !rs;
  assign bank_wr = wr_en && rs;
  assign bank_rd = rd_en && rs;

  assign sel_fifo = (addr_q == AW'(RA_FIFO));
  assign sel_ctrl = (addr_q == AW'(RA_CTRL));
  assign sel_cmd  = (addr_q == AW'(RA_CMD));

  assign wf_push   = bank_wr && sel_fifo;
  assign rf_pop    = bank_rd && sel_fifo;
  assign abort_req = bank_wr && sel_ctrl && wdata[CB_ABORT];

  hostreg_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_wfifo (
    .clk(clk), .rst_n(rst_n), .flush(abort_req),
    .push(wf_push), .din(wdata), .pop(fetch),
    .dout(wf_head), .empty(wf_empty), .full(wf_full),
    .push_drop(wf_drop), .pop_miss(wf_miss_unused)
  );

  hostreg_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rfifo (
    .clk(clk), .rst_n(rst_n), .flush(abort_req),
    .push(hook_push), .din(hook_data), .pop(rf_pop),
    .dout(rf_head), .empty(rf_empty), .full(rf_full_unused),
    .push_drop(rf_drop_unused), .pop_miss(rf_miss)
  );

  assign wf_pop_unused = fetch && wf_empty;

  hostreg_cmd_fetch #(.DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .abort(abort_req), .pause(ctrl_q[CB_PAUSE]),
    .done(exec_done), .q_empty(wf_empty), .q_head(wf_head),
    .fetch(fetch), .cmd_word(cmd_word), .busy(cmd_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (ptr_wr) addr_q <= wdata[AW-1:0];
      if (bank_wr && sel_ctrl) ctrl_q <= wdata[7:1];
      ovf_q <= stat_rd ? 1'b0 : (ovf_q | wf_drop);
      unf_q <= stat_rd ? 1'b0 : (unf_q | rf_miss);
    end
  end

  always_comb begin
    stat              = '0;
    stat[ST_WF_EMPTY] = wf_empty;
    stat[ST_WF_FULL]  = wf_full;
    stat[ST_RF_READY] = !rf_empty;
    stat[ST_BUSY]     = cmd_busy;
    stat[ST_OVF]      = ovf_q;
    stat[ST_UNF]      = unf_q;
    stat[ST_IRQ]      = irq_of(stat[5:0], ctrl_q[7:CB_IE_LSB]);
  end

  assign irq = stat[ST_IRQ];

  always_comb begin
    rdata = '0;
    if (!rs) begin
      rdata[ST_W-1:0] = stat;
      rdata[8 +: AW]  = addr_q;
    end else if (sel_fifo) begin
      rdata = rf_empty ? '0 : rf_head;
    end else if (sel_ctrl) begin
      rdata[7:0] = {ctrl_q, 1'b0};
    end else if (sel_cmd) begin
      rdata = cmd_word;
    end
  end

  assert_addr_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> addr_q == $past(wdata[AW-1:0]));
  assert_drop_sets_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wf_drop |=> ovf_q);
  assert_miss_sets_unf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_miss |=> unf_q);
  assert_stat_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (!ovf_q && !unf_q));
  assert_ctrl_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_wr && sel_ctrl) |=> $stable(ctrl_q));
endmodule

// File: tb/test_hostreg_port.sv
module test_hostreg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        exec_done = 1'b0, hook_push = 1'b0;
  logic [15:0] hook_data = '0;
  logic [15:0] cmd_word;
  logic        cmd_busy, irq;
  int          total = 0, bad = 0;
  logic        finished = 1'b0;

  always #10 clk = ~clk;

  hostreg_port i_hostreg_port (
    .clk(clk), .rst_n(rst_n), .rs(rs), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .exec_done(exec_done),
    .hook_push(hook_push), .hook_data(hook_data),
    .cmd_word(cmd_word), .cmd_busy(cmd_busy), .irq(irq)
  );

  function automatic logic [15:0] wv(int i);
    return 16'h1000 + 16'(i) * 16'h0101;
  endfunction
  function automatic logic [15:0] rv(int i);
    return 16'hC001 + 16'(i) * 16'h0011;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic s, input logic [15:0] d);
    @(negedge clk); rs = s; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic s, output logic [15:0] q);
    @(negedge clk); rs = s; rd_en = 1'b1;
    #1 q = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ctrl_wr(input logic [15:0] v);
    bus_wr(1'b0, 16'd1);
    bus_wr(1'b1, v);
  endtask

  task automatic done_pulse();
    @(negedge clk); exec_done = 1'b1;
    @(negedge clk); exec_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] q, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", 16'(cmd_busy), 16'd0);
    chk("R11 cmd", cmd_word, 16'd0);
    chk("R11 irq", 16'(irq), 16'd0);
    bus_rd(1'b0, q); chk("R11 status", q, 16'h0001);
    bus_wr(1'b0, 16'd1); bus_rd(1'b1, q); chk("R11 ctrl", q, 16'h0000);

    // R1 pointer latch sweep
    for (int a = 0; a < 4; a++) begin
      bus_wr(1'b0, 16'hAB00 | 16'(a));
      bus_rd(1'b0, q); chk("R1 pointer", q, (16'(a) << 8) | 16'h0001);
    end
    bus_wr(1'b0, 16'h00FF); bus_rd(1'b0, q); chk("R1 low bits", q, 16'h0301);

    // R2 R4 R7 write FIFO fill sweep with fetch order
    for (int n = 0; n <= 10; n++) begin
      ctrl_wr(16'h0003);
      bus_wr(1'b0, 16'd0);
      for (int i = 0; i < n; i++) bus_wr(1'b1, wv(i));
      bus_rd(1'b0, q);
      e = '0; e[0] = (n == 0); e[1] = (n >= 8); e[4] = (n > 8);
      chk("R2 R4 fill status", q, e);
      ctrl_wr(16'h0000);
      for (int i = 0; i < ((n > 8) ? 8 : n); i++) begin
        @(posedge clk); @(negedge clk);
        chk("R7 busy on fetch", 16'(cmd_busy), 16'd1);
        chk("R7 R4 fetch order", cmd_word, wv(i));
        exec_done = 1'b1;
        @(posedge clk); @(negedge clk);
        exec_done = 1'b0;
        chk("R7 done clears", 16'(cmd_busy), 16'd0);
      end
      bus_rd(1'b0, q); chk("R7 drained", q, 16'h0101);
    end

    // R8 pause with a running command
    bus_wr(1'b0, 16'd0);
    bus_wr(1'b1, wv(0)); bus_wr(1'b1, wv(1));
    chk("R7 first fetched", cmd_word, wv(0));
    ctrl_wr(16'h0002);
    done_pulse();
    repeat (4) @(negedge clk);
    chk("R8 paused idle", 16'(cmd_busy), 16'd0);
    bus_rd(1'b0, q); chk("R8 word held", q, 16'h0100);
    ctrl_wr(16'h0000);
    @(posedge clk); @(negedge clk);
    chk("R8 resume busy", 16'(cmd_busy), 16'd1);
    chk("R8 resume word", cmd_word, wv(1));
    done_pulse();

    // R5 R6 read FIFO sweep
    for (int k = 0; k <= 9; k++) begin
      ctrl_wr(16'h0003);
      for (int i = 0; i < k; i++) begin
        @(negedge clk); hook_push = 1'b1; hook_data = rv(i);
      end
      @(negedge clk); hook_push = 1'b0;
      bus_wr(1'b0, 16'd0);
      bus_rd(1'b0, q); chk("R2 R5 rf ready", q, (k > 0) ? 16'h0005 : 16'h0001);
      for (int i = 0; i < ((k > 8) ? 8 : k); i++) begin
        bus_rd(1'b1, q); chk("R5 pop order", q, rv(i));
      end
      bus_rd(1'b1, q); chk("R5 empty read zero", q, 16'h0000);
      bus_rd(1'b0, q); chk("R5 underflow set", q, 16'h0021);
      bus_rd(1'b0, q); chk("R6 cleared", q, 16'h0001);
    end

    // R9 abort
    ctrl_wr(16'h0000);
    bus_wr(1'b0, 16'd0);
    for (int i = 0; i < 3; i++) bus_wr(1'b1, wv(i));
    @(negedge clk); hook_push = 1'b1; hook_data = rv(0);
    @(negedge clk); hook_push = 1'b0;
    chk("R9 busy before", 16'(cmd_busy), 16'd1);
    ctrl_wr(16'h0001);
    chk("R9 busy cleared", 16'(cmd_busy), 16'd0);
    chk("R9 cmd zero", cmd_word, 16'd0);
    bus_rd(1'b1, q); chk("R9 abort reads zero", q, 16'h0000);
    bus_rd(1'b0, q); chk("R9 flushed", q, 16'h0101);

    // R10 enables against status 0x01
    for (int j = 0; j < 6; j++) begin
      ctrl_wr(16'(1 << (j + 2)));
      chk("R10 irq empty vec", 16'(irq), 16'(j == 0));
    end
    ctrl_wr(16'h0004);
    bus_rd(1'b0, q); chk("R2 irq bit", q, 16'h0141);
    // R10 enables against status 0x12
    ctrl_wr(16'h0002);
    bus_wr(1'b0, 16'd0);
    for (int i = 0; i < 9; i++) bus_wr(1'b1, wv(i));
    for (int j = 0; j < 6; j++) begin
      ctrl_wr(16'h0002 | 16'(1 << (j + 2)));
      chk("R10 irq full vec", 16'(irq), 16'(j == 1 || j == 4));
    end
    ctrl_wr(16'h0042);
    bus_rd(1'b0, q); chk("R6 R10 status", q, 16'h0152);
    chk("R6 R10 irq drops", 16'(irq), 16'd0);

    // R3 reserved and read-only targets
    bus_wr(1'b0, 16'd3);
    bus_rd(1'b1, q); chk("R3 reserved read", q, 16'h0000);
    bus_wr(1'b1, 16'hFFFF);
    bus_rd(1'b0, q); chk("R3 reserved write", q, 16'h0302);
    bus_wr(1'b0, 16'd1);
    bus_rd(1'b1, q); chk("R3 ctrl kept", q, 16'h0042);
    ctrl_wr(16'h0000);
    @(negedge clk);
    bus_wr(1'b0, 16'd2);
    bus_rd(1'b1, q); chk("R3 cmd read", q, wv(0));
    bus_wr(1'b1, 16'h5555);
    bus_rd(1'b1, q); chk("R3 cmd read-only", q, wv(0));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule